// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped line cache with a small fully associative victim buffer beside it. A processor sends word reads and writes over a valid/ready request port. Each lookup first checks the primary slot selected by the index bits. On a primary miss, every victim entry is compared against the full line address. A victim hit exchanges the victim line and the primary line in one extra cycle. A miss in both structures fetches the whole line over a refill port. The incoming line takes the primary slot, and the line it displaces moves into a victim entry.

The victim buffer holds only lines that were pushed out of the primary array. Its entries are shared by all sets, so only sets that actually conflict take up space in it. An invalid entry is filled first. When every entry is valid, the least recently used entry is overwritten and its line is dropped. Writes go straight through to memory. A write updates the cached word when the line is present and does not allocate a line on a miss. Every response carries exactly one outcome flag: primary hit, victim hit or miss.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_req and mem_wr are 0. Every primary and victim line is invalid, so the first access to any address reports a miss.
- R2: A request accepted on a clock edge that hits the primary array raises rsp_valid and rsp_hit for one cycle on the next clock edge. rsp_rdata then holds the addressed word.
- R3: A read that misses in both structures holds mem_req high with mem_line_addr = req_addr[AW-1:log2(WORDS)] until mem_ack. The response arrives on the mem_ack edge with rsp_miss. Word w of a line occupies bits [w*DW +: DW] of mem_rdata, and the fetched line then sits in the primary array.
- R4: A primary miss that hits a victim entry returns rsp_vhit one clock edge later than a primary hit would, with the line's data. That line then sits in the primary array.
- R5: The line displaced from a valid primary slot, either by a refill or by a victim swap, goes into the victim buffer and can be reached there. A line is never present in both the primary array and the victim buffer.
- R6: A line entering the victim buffer takes the lowest-numbered invalid entry. If no entry is invalid, it takes the least recently used entry. An entry counts as used when it is written by a refill or by a swap. The line that was overwritten then misses.
- R7: Every write produces a one-cycle mem_wr pulse carrying its address and data. A write that hits in the primary array or in the victim buffer updates the cached word; a victim-hit write also swaps the line into the primary array. A write that misses in both reports rsp_miss, issues no refill and allocates nothing.
- R8: While rsp_valid is high, exactly one of rsp_hit, rsp_vhit and rsp_miss is high, and all three are low otherwise. A write response returns the written data on rsp_rdata.
- R9: With VICTIMS = 1, the block still swaps on a victim hit and drops the older victim when a new line is displaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DW | Read word, or echoed write data |
| rsp_hit | output | 1 | Outcome: primary hit |
| rsp_vhit | output | 1 | Outcome: victim hit |
| rsp_miss | output | 1 | Outcome: miss in both structures |
| mem_req | output | 1 | Line refill request |
| mem_line_addr | output | AW-log2(WORDS) | Line address of the refill |
| mem_ack | input | 1 | Refill data valid |
| mem_rdata | input | WORDS*DW | Whole refill line |
| mem_wr | output | 1 | Write-through strobe |
| mem_wr_addr | output | AW | Write-through word address |
| mem_wr_data | output | DW | Write-through data |

## Verification
The main stimulus is a run of accesses to six lines that all map to set 0. The run pushes lines out and back in, first while the victim buffer still has free entries and then while it is full. This shows whether a refill, a swap and a drop each happen at the right access, and the latency measured on each access separates a primary hit from a swap. Writes are placed on a primary hit, on a victim hit and on a miss, and later reads of the same words show whether the word was updated in the cache, written through to memory or allocated by mistake. Accesses to a second set show that sets with no conflicts do not use victim entries. A short sequence on a one-entry instance and a second reset complete the run.

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int SETS    = 16,
  parameter int WORDS   = 4,
  parameter int VICTIMS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   rsp_hit,
  output logic                   rsp_vhit,
  output logic                   rsp_miss,
  output logic                   mem_req,
  output logic [AW-$clog2(WORDS)-1:0] mem_line_addr,
  input  logic                   mem_ack,
  input  logic [WORDS*DW-1:0]    mem_rdata,
  output logic                   mem_wr,
  output logic [AW-1:0]          mem_wr_addr,
  output logic [DW-1:0]          mem_wr_data
);
  localparam int OW    = $clog2(WORDS);
  localparam int IW    = $clog2(SETS);
  localparam int TW    = AW - IW - OW;
  localparam int LW    = AW - OW;
  localparam int LINEW = WORDS * DW;
  localparam int VW    = (VICTIMS > 1) ? $clog2(VICTIMS) : 1;

  typedef enum logic [1:0] {IDLE, LOOK, SWAP, FILL} st_t;

  st_t              st;
  logic [AW-1:0]    a_q;
  logic             wr_q;
  logic [DW-1:0]    wd_q;
  logic [VW-1:0]    sel_q;

  logic             p_valid [SETS];
  logic [TW-1:0]    p_tag   [SETS];
  logic [LINEW-1:0] p_data  [SETS];
  logic             v_valid [VICTIMS];
  logic [LW-1:0]    v_line  [VICTIMS];
  logic [LINEW-1:0] v_data  [VICTIMS];
  logic [VW-1:0]    v_rank  [VICTIMS];

  logic [IW-1:0] idx;
  logic [TW-1:0] tag;
  logic [OW-1:0] wsel;
  logic [LW-1:0] line;
  assign idx  = a_q[OW +: IW];
  assign tag  = a_q[AW-1 -: TW];
  assign wsel = a_q[OW-1:0];
  assign line = a_q[AW-1:OW];

  logic p_hit;
  assign p_hit = p_valid[idx] && (p_tag[idx] == tag);

  logic          v_hit, have_free;
  logic [VW-1:0] v_sel, tgt;
  always_comb begin
    v_hit = 1'b0; v_sel = '0; tgt = '0; have_free = 1'b0;
    for (int i = VICTIMS-1; i >= 0; i--) begin
      if (v_valid[i] && v_line[i] == line) begin v_hit = 1'b1; v_sel = VW'(i); end
      if (!v_valid[i]) begin have_free = 1'b1; tgt = VW'(i); end
    end
    if (!have_free)
      for (int i = 0; i < VICTIMS; i++)
        if (v_rank[i] == VW'(VICTIMS-1)) tgt = VW'(i);
  end

  function automatic logic [LINEW-1:0] put_word(input logic [LINEW-1:0] l,
                                                input logic [OW-1:0] w,
                                                input logic [DW-1:0] d);
    put_word = l;
    put_word[int'(w)*DW +: DW] = d;
  endfunction

  logic          touch_en;
  logic [VW-1:0] touch_idx;
  assign touch_en  = (st == SWAP) || (st == FILL && mem_ack && p_valid[idx]);
  assign touch_idx = (st == SWAP) ? sel_q : tgt;

  assign req_ready     = (st == IDLE);
  assign mem_req       = (st == FILL);
  assign mem_line_addr = line;
  assign mem_wr        = (st == LOOK) && wr_q;
  assign mem_wr_addr   = a_q;
  assign mem_wr_data   = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; a_q <= '0; wr_q <= 1'b0; wd_q <= '0; sel_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
      rsp_hit <= 1'b0; rsp_vhit <= 1'b0; rsp_miss <= 1'b0;
      for (int s = 0; s < SETS; s++) p_valid[s] <= 1'b0;
      for (int i = 0; i < VICTIMS; i++) begin
        v_valid[i] <= 1'b0;
        v_rank[i]  <= VW'(i);
      end
    end else begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_vhit <= 1'b0; rsp_miss <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          a_q <= req_addr; wr_q <= req_write; wd_q <= req_wdata; st <= LOOK;
        end
        LOOK: begin
          if (p_hit) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b1;
            rsp_rdata <= wr_q ? wd_q : p_data[idx][int'(wsel)*DW +: DW];
            st <= IDLE;
          end else if (v_hit) begin
            sel_q <= v_sel; st <= SWAP;
          end else if (wr_q) begin
            rsp_valid <= 1'b1; rsp_miss <= 1'b1; rsp_rdata <= wd_q; st <= IDLE;
          end else begin
            st <= FILL;
          end
        end
        SWAP: begin
          rsp_valid <= 1'b1; rsp_vhit <= 1'b1;
          rsp_rdata <= wr_q ? wd_q : v_data[sel_q][int'(wsel)*DW +: DW];
          p_valid[idx]   <= 1'b1;
          v_valid[sel_q] <= p_valid[idx];
          st <= IDLE;
        end
        FILL: if (mem_ack) begin
          rsp_valid <= 1'b1; rsp_miss <= 1'b1;
          rsp_rdata <= mem_rdata[int'(wsel)*DW +: DW];
          p_valid[idx] <= 1'b1;
          if (p_valid[idx]) v_valid[tgt] <= 1'b1;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
      if (touch_en)
        for (int j = 0; j < VICTIMS; j++)
          if (VW'(j) == touch_idx) v_rank[j] <= '0;
          else if (v_rank[j] < v_rank[touch_idx]) v_rank[j] <= v_rank[j] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st == LOOK && p_hit && wr_q)
      p_data[idx] <= put_word(p_data[idx], wsel, wd_q);
    if (st == SWAP) begin
      p_data[idx]   <= wr_q ? put_word(v_data[sel_q], wsel, wd_q) : v_data[sel_q];
      p_tag[idx]    <= v_line[sel_q][LW-1 -: TW];
      v_data[sel_q] <= p_data[idx];
      v_line[sel_q] <= {p_tag[idx], idx};
    end
    if (st == FILL && mem_ack) begin
      p_data[idx] <= mem_rdata;
      p_tag[idx]  <= tag;
      if (p_valid[idx]) begin
        v_data[tgt] <= p_data[idx];
        v_line[tgt] <= {p_tag[idx], idx};
      end
    end
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < VICTIMS; i++)
      for (int j = i + 1; j < VICTIMS; j++)
        if (v_valid[i] && v_valid[j] && v_line[i] == v_line[j]) dup = 1'b1;
  end

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_vhit, rsp_miss}) == 1);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_vhit || rsp_miss));
  a_r2_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid);
  a_r4_vhit_from_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_vhit) |-> $past(st == SWAP));
  a_r3_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line_addr)));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOOK) |-> !(p_hit && v_hit));
  a_r5_unique_victims: assert property (@(posedge clk) disable iff (!rst_n) !dup);
endmodule

// File: tb/dm_victim_cache_bench.sv
`timescale 1ns/1ps
module dm_victim_cache_bench;
  localparam int AW = 10, DW = 16, WORDS = 4, LW = 8;
  localparam int K_MISS = 0, K_HIT = 1, K_VHIT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid_a = 0, req_write_a = 0, req_valid_b = 0, req_write_b = 0;
  logic [AW-1:0] req_addr_a = '0, req_addr_b = '0;
  logic [DW-1:0] req_wdata_a = '0, req_wdata_b = '0;
  logic req_ready_a, rsp_valid_a, rsp_hit_a, rsp_vhit_a, rsp_miss_a, mem_req_a, mem_wr_a;
  logic req_ready_b, rsp_valid_b, rsp_hit_b, rsp_vhit_b, rsp_miss_b, mem_req_b, mem_wr_b;
  logic [DW-1:0] rsp_rdata_a, rsp_rdata_b, mem_wr_data_a, mem_wr_data_b;
  logic [LW-1:0] mem_line_addr_a, mem_line_addr_b;
  logic [AW-1:0] mem_wr_addr_a, mem_wr_addr_b;
  logic mem_ack_a = 0, mem_ack_b = 0;
  logic [WORDS*DW-1:0] mem_rdata_a = '0, mem_rdata_b = '0;

  dm_victim_cache #(.AW(AW), .DW(DW), .SETS(16), .WORDS(WORDS), .VICTIMS(4)) u_dm_victim_cache (
    .clk, .rst_n, .req_valid(req_valid_a), .req_ready(req_ready_a), .req_write(req_write_a),
    .req_addr(req_addr_a), .req_wdata(req_wdata_a), .rsp_valid(rsp_valid_a), .rsp_rdata(rsp_rdata_a),
    .rsp_hit(rsp_hit_a), .rsp_vhit(rsp_vhit_a), .rsp_miss(rsp_miss_a), .mem_req(mem_req_a),
    .mem_line_addr(mem_line_addr_a), .mem_ack(mem_ack_a), .mem_rdata(mem_rdata_a),
    .mem_wr(mem_wr_a), .mem_wr_addr(mem_wr_addr_a), .mem_wr_data(mem_wr_data_a));

  dm_victim_cache #(.AW(AW), .DW(DW), .SETS(16), .WORDS(WORDS), .VICTIMS(1)) u_dm_victim_cache_one (
    .clk, .rst_n, .req_valid(req_valid_b), .req_ready(req_ready_b), .req_write(req_write_b),
    .req_addr(req_addr_b), .req_wdata(req_wdata_b), .rsp_valid(rsp_valid_b), .rsp_rdata(rsp_rdata_b),
    .rsp_hit(rsp_hit_b), .rsp_vhit(rsp_vhit_b), .rsp_miss(rsp_miss_b), .mem_req(mem_req_b),
    .mem_line_addr(mem_line_addr_b), .mem_ack(mem_ack_b), .mem_rdata(mem_rdata_b),
    .mem_wr(mem_wr_b), .mem_wr_addr(mem_wr_addr_b), .mem_wr_data(mem_wr_data_b));

  logic [DW-1:0] mem_a [1024];
  logic [DW-1:0] mem_b [1024];
  int cnt_a = 0, cnt_b = 0, fills_a = 0, wr_cnt_a = 0;
  logic [LW-1:0] last_line_a = '0;
  logic [AW-1:0] wr_addr_seen = '0;
  logic [DW-1:0] wr_data_seen = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  initial for (int i = 0; i < 1024; i++) begin
    mem_a[i] = DW'(i) ^ 16'hA500;
    mem_b[i] = DW'(i) ^ 16'hA500;
  end

  always @(posedge clk) begin
    if (mem_wr_a) begin
      mem_a[mem_wr_addr_a] = mem_wr_data_a;
      wr_cnt_a++; wr_addr_seen = mem_wr_addr_a; wr_data_seen = mem_wr_data_a;
    end
    if (mem_wr_b) mem_b[mem_wr_addr_b] = mem_wr_data_b;
  end

  always @(negedge clk) begin
    if (mem_req_a && !mem_ack_a) begin
      cnt_a++;
      if (cnt_a == 3) begin
        for (int w = 0; w < WORDS; w++) mem_rdata_a[w*DW +: DW] = mem_a[int'(mem_line_addr_a)*WORDS + w];
        mem_ack_a = 1; fills_a++; last_line_a = mem_line_addr_a;
      end
    end else if (!mem_req_a) begin mem_ack_a = 0; cnt_a = 0; end
    if (mem_req_b && !mem_ack_b) begin
      cnt_b++;
      if (cnt_b == 3) begin
        for (int w = 0; w < WORDS; w++) mem_rdata_b[w*DW +: DW] = mem_b[int'(mem_line_addr_b)*WORDS + w];
        mem_ack_b = 1;
      end
    end else if (!mem_req_b) begin mem_ack_b = 0; cnt_b = 0; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit which, input bit wr, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, output int kind, output int data, output int lat);
    @(negedge clk);
    while (!(which ? req_ready_b : req_ready_a)) @(negedge clk);
    if (which) begin req_valid_b = 1; req_write_b = wr; req_addr_b = addr; req_wdata_b = wd; end
    else       begin req_valid_a = 1; req_write_a = wr; req_addr_a = addr; req_wdata_a = wd; end
    @(negedge clk);
    req_valid_a = 0; req_valid_b = 0;
    lat = 1;
    while (!(which ? rsp_valid_b : rsp_valid_a)) begin @(negedge clk); lat++; end
    if (which) begin
      kind = rsp_hit_b ? K_HIT : rsp_vhit_b ? K_VHIT : rsp_miss_b ? K_MISS : 3;
      data = int'(rsp_rdata_b);
    end else begin
      kind = rsp_hit_a ? K_HIT : rsp_vhit_a ? K_VHIT : rsp_miss_a ? K_MISS : 3;
      data = int'(rsp_rdata_a);
    end
  endtask

  // {write, addr, data (read expect or write value), outcome}; all set-0 lines collide
  localparam logic [28:0] VEC [22] = '{
    {1'b0, 10'h000, 16'hA500, 2'd0}, {1'b0, 10'h001, 16'hA501, 2'd1},
    {1'b0, 10'h040, 16'hA540, 2'd0}, {1'b0, 10'h002, 16'hA502, 2'd2},
    {1'b0, 10'h041, 16'hA541, 2'd2}, {1'b1, 10'h043, 16'h1234, 2'd1},
    {1'b0, 10'h043, 16'h1234, 2'd1}, {1'b1, 10'h0C1, 16'h5555, 2'd0},
    {1'b0, 10'h0C1, 16'h5555, 2'd0}, {1'b0, 10'h080, 16'hA580, 2'd0},
    {1'b0, 10'h100, 16'hA400, 2'd0}, {1'b0, 10'h140, 16'hA440, 2'd0},
    {1'b0, 10'h000, 16'hA500, 2'd0}, {1'b0, 10'h043, 16'h1234, 2'd0},
    {1'b0, 10'h080, 16'hA580, 2'd2}, {1'b0, 10'h101, 16'hA401, 2'd2},
    {1'b0, 10'h3FF, 16'hA6FF, 2'd0}, {1'b0, 10'h3FC, 16'hA6FC, 2'd1},
    {1'b1, 10'h102, 16'h7777, 2'd1}, {1'b0, 10'h102, 16'h7777, 2'd1},
    {1'b1, 10'h081, 16'h4242, 2'd2}, {1'b0, 10'h081, 16'h4242, 2'd1}
  };

  localparam logic [27:0] ONE [7] = '{
    {10'h000, 16'hA500, 2'd0}, {10'h040, 16'hA540, 2'd0}, {10'h000, 16'hA500, 2'd2},
    {10'h040, 16'hA540, 2'd2}, {10'h080, 16'hA580, 2'd0}, {10'h041, 16'hA541, 2'd2},
    {10'h000, 16'hA500, 2'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int kind, data, lat, f0, w0;
    repeat (3) @(negedge clk);
    check(req_ready_a == 1, "R1 ready", req_ready_a, 1);
    check(rsp_valid_a == 0, "R1 rsp_valid", rsp_valid_a, 0);
    rst_n = 1;
    @(negedge clk);
    check(mem_req_a == 0 && mem_wr_a == 0, "R1 mem idle", {mem_req_a, mem_wr_a}, 0);

    for (int v = 0; v < 22; v++) begin
      f0 = fills_a; w0 = wr_cnt_a;
      access(0, VEC[v][28], VEC[v][27:18], VEC[v][17:2], kind, data, lat);
      check(kind == int'(VEC[v][1:0]), $sformatf("R4/R5/R6 outcome v%0d", v), kind, VEC[v][1:0]);
      check(data == int'(VEC[v][17:2]), $sformatf("R2/R3/R8 data v%0d", v), data, VEC[v][17:2]);
      if (kind == K_HIT)  check(lat == 2, $sformatf("R2 hit latency v%0d", v), lat, 2);
      if (kind == K_VHIT) check(lat == 3, $sformatf("R4 swap latency v%0d", v), lat, 3);
      if (!VEC[v][28] && VEC[v][1:0] == 2'd0)
        check(last_line_a == VEC[v][27:20] && fills_a == f0 + 1, $sformatf("R3 refill line v%0d", v),
              last_line_a, VEC[v][27:20]);
      if (VEC[v][28]) begin
        check(wr_cnt_a == w0 + 1 && wr_addr_seen == VEC[v][27:18] && wr_data_seen == VEC[v][17:2],
              $sformatf("R7 write-through v%0d", v), wr_data_seen, VEC[v][17:2]);
        check(fills_a == f0, $sformatf("R7 no refill on write v%0d", v), fills_a, f0);
      end
    end

    for (int v = 0; v < 7; v++) begin
      access(1, 0, ONE[v][27:18], '0, kind, data, lat);
      check(kind == int'(ONE[v][1:0]), $sformatf("R9 one-entry outcome s%0d", v), kind, ONE[v][1:0]);
      check(data == int'(ONE[v][17:2]), $sformatf("R9 one-entry data s%0d", v), data, ONE[v][17:2]);
    end

    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check(rsp_valid_a == 0 && req_ready_a == 1, "R1 re-reset idle", rsp_valid_a, 0);
    rst_n = 1;
    access(0, 0, 10'h3FC, '0, kind, data, lat);
    check(kind == K_MISS, "R1 lines invalid after reset", kind, K_MISS);
    check(data == 16'hA6FC, "R1 data after reset", data, 16'hA6FC);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule